// File: doc/BRIEF.md
# Supply Warning Interrupt Controller

This block is the digital supervisor that sits behind an auxiliary supply-voltage warning comparator. It receives two asynchronous comparator outputs: one watching the main supply and one watching an external monitor pin. A select bit picks which of the two is used. The chosen signal is synchronized and exposed as a read-only warning flag that tracks the comparator as it moves. When the interrupt is enabled, the block raises an interrupt request on every change of that flag. A falling supply gives an early-warning interrupt, and a recovering supply gives a warning-over interrupt.

The whole function is tied to the configuration bit that enables the low-voltage reset. With that bit off, the flag stays low and no request is ever made. After reset release, a delay window of 256 or 4096 clock cycles masks crossings. A supply that recovers quickly during power-up therefore does not produce a spurious interrupt. Turning the enable on while the warning is already active produces a request at once, so software never misses a warning that started before it was listening.

The request is a sticky pending bit that software removes with a one-cycle clear pulse.

Top module: `supply_warn_ctrl`

## Requirements
- R1: When `lvdEn` is 0, `warnFlag` is 0 and `irqPend` is 0, whatever the comparator inputs do.
- R2: `srcSel` = 0 selects `supplyCmp` and `srcSel` = 1 selects `pinCmp`. A comparator level of 1 means the watched voltage is below its threshold (warning active).
- R3: `warnFlag` equals the selected comparator level, delayed through a two-flop synchronizer. It is visible after the second rising clock edge that follows the input change. After reset it is 0.
- R4: With `irqEn` = 1 and the delay window over, each change of `warnFlag`, rising or falling, sets `irqPend` on the next clock edge. That is the third edge after the comparator change.
- R5: `irqPend` stays set until `irqClr` is 1 for a clock edge, which clears it. If a new event coincides with the clear, `irqPend` stays set.
- R6: After reset release, flag changes set no interrupt while fewer than 256 cycles (`longDelay` = 0) or 4096 cycles (`longDelay` = 1) have elapsed. `warnFlag` still tracks its input during this window.
- R7: A 0-to-1 change of `irqEn` while `warnFlag` is 1 sets `irqPend` on the next edge, even inside the delay window. A later flag change outside the window sets it again.
- R8: A 0-to-1 change of `irqEn` while `warnFlag` is 0 does not set `irqPend`.
- R9: Changing `srcSel` does not by itself set `irqPend`, even when the two inputs differ.
- R10: With `irqEn` = 0, flag changes do not set `irqPend`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyCmp | input | 1 | Main-supply comparator, 1 = below threshold |
| pinCmp | input | 1 | External pin comparator, 1 = below threshold |
| srcSel | input | 1 | 0 = main supply, 1 = external pin |
| irqEn | input | 1 | Interrupt enable |
| lvdEn | input | 1 | Low-voltage reset enabled by configuration; gates the whole function |
| longDelay | input | 1 | Post-reset mask window: 0 = 256 cycles, 1 = 4096 cycles |
| irqClr | input | 1 | One-cycle pulse that clears the pending request |
| warnFlag | output | 1 | Real-time warning flag |
| irqPend | output | 1 | Sticky interrupt request |

## Verification
The bench drives crossings inside the post-reset window for both window lengths. A design with a wrong or missing mask would raise a power-up interrupt there, and one that also froze the flag would stop tracking the supply. The bench times a new event so that it lands in the same cycle as a clear. A design that gives the clear priority would lose that request. It toggles the source select while the two comparators disagree, which catches an edge detector that is not reloaded and fires a phantom interrupt. It also turns the enable on with the warning both active and inactive. A design that ignores this case would miss a standing warning, and one that is too eager would report a warning that does not exist.

// File: rtl/supply_warn_pkg.sv
package supply_warn_pkg;

  // Datapath status seen by the control
  typedef struct packed {
    logic flag;     // current gated warning level
    logic edgeEvt;  // flag changed with the source held steady
  } dp_status_t;

  // Strobes from control to the datapath pending bit
  typedef struct packed {
    logic setPend;
    logic clrPend;
  } ctl_strobe_t;

endpackage

// File: rtl/supply_warn_sync.sv
module supply_warn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/supply_warn_dp.sv
module supply_warn_dp
  import supply_warn_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        supplyCmp,
  input  logic        pinCmp,
  input  logic        srcSel,
  input  logic        lvdEn,
  input  ctl_strobe_t strobe,
  output dp_status_t  status,
  output logic        irqPend
);
  localparam int N_SRC = 2;

  logic [N_SRC-1:0] rawIn;
  logic [N_SRC-1:0] syncd;
  logic             selCmp;
  logic             flag;
  logic             flagQ;
  logic             srcSelQ;

  assign rawIn = {pinCmp, supplyCmp};

  for (genvar i = 0; i < N_SRC; i++) begin : g_sync
    supply_warn_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rstN (rstN),
      .din  (rawIn[i]),
      .dout (syncd[i])
    );
  end

  assign selCmp = syncd[srcSel];
  assign flag   = lvdEn & selCmp;

  // previous flag and previous select; a select change reloads the detector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ   <= 1'b0;
      srcSelQ <= 1'b0;
    end else begin
      flagQ   <= flag;
      srcSelQ <= srcSel;
    end
  end

  assign status.flag    = flag;
  assign status.edgeEvt = (flag != flagQ) && (srcSel == srcSelQ);

  // sticky pending bit, set wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               irqPend <= 1'b0;
    else if (strobe.setPend) irqPend <= 1'b1;
    else if (strobe.clrPend) irqPend <= 1'b0;
  end
endmodule

// File: rtl/supply_warn_ctl.sv
module supply_warn_ctl
  import supply_warn_pkg::*;
#(
  parameter int SHORT_DELAY = 256,
  parameter int LONG_DELAY  = 4096
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        irqEn,
  input  logic        lvdEn,
  input  logic        longDelay,
  input  logic        irqClr,
  input  dp_status_t  status,
  output ctl_strobe_t strobe
);
  localparam int CNT_W = $clog2(LONG_DELAY + 1);
  localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_DELAY);
  localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_DELAY);

  logic [CNT_W-1:0] dlyCnt;
  logic [CNT_W-1:0] limit;
  logic             windowOpen;
  logic             irqEnQ;
  logic             enRise;

  // up-counter from reset release, saturating at the long limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  dlyCnt <= '0;
    else if (dlyCnt != LONG_LIM) dlyCnt <= dlyCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqEnQ <= 1'b0;
    else       irqEnQ <= irqEn;
  end

  assign limit      = longDelay ? LONG_LIM : SHORT_LIM;
  assign windowOpen = (dlyCnt >= limit);
  assign enRise     = irqEn & ~irqEnQ;

  assign strobe.setPend = lvdEn & irqEn &
                          ((status.edgeEvt & windowOpen) | (enRise & status.flag));
  assign strobe.clrPend = irqClr | ~lvdEn;
endmodule

// File: rtl/supply_warn_ctrl.sv
module supply_warn_ctrl
  import supply_warn_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SHORT_DELAY = 256,
  parameter int LONG_DELAY  = 4096
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyCmp,
  input  logic pinCmp,
  input  logic srcSel,
  input  logic irqEn,
  input  logic lvdEn,
  input  logic longDelay,
  input  logic irqClr,
  output logic warnFlag,
  output logic irqPend
);
  dp_status_t  status;
  ctl_strobe_t strobe;

  supply_warn_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .supplyCmp (supplyCmp),
    .pinCmp    (pinCmp),
    .srcSel    (srcSel),
    .lvdEn     (lvdEn),
    .strobe    (strobe),
    .status    (status),
    .irqPend   (irqPend)
  );

  supply_warn_ctl #(.SHORT_DELAY(SHORT_DELAY), .LONG_DELAY(LONG_DELAY)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .irqEn     (irqEn),
    .lvdEn     (lvdEn),
    .longDelay (longDelay),
    .irqClr    (irqClr),
    .status    (status),
    .strobe    (strobe)
  );

  assign warnFlag = status.flag;
endmodule

// File: rtl/supply_warn_chk.sv
module supply_warn_chk #(
  parameter int SHORT_DELAY = 256,
  parameter int LONG_DELAY  = 4096
) (
  input logic clk,
  input logic rstN,
  input logic irqEn,
  input logic lvdEn,
  input logic irqClr,
  input logic warnFlag,
  input logic irqPend
);
  localparam int CW = $clog2(LONG_DELAY + 1);
  logic [CW-1:0] chkCnt;
  logic          early;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        chkCnt <= '0;
    else if (chkCnt != CW'(LONG_DELAY)) chkCnt <= chkCnt + 1'b1;
  end

  assign early = (chkCnt < CW'(SHORT_DELAY));

  a_r1_off_no_flag: assert property (@(posedge clk) disable iff (!rstN)
    !lvdEn |-> !warnFlag);

  a_r1_off_no_irq: assert property (@(posedge clk) disable iff (!rstN)
    !lvdEn |=> !irqPend);

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irqPend && !irqClr && lvdEn) |=> irqPend);

  a_r10_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqPend) |-> $past(irqEn));

  // R6/R7: inside the short window only an enable rise may raise a request
  a_r6_window_mask: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(irqPend) && early) |-> ($past(irqEn) && !$past(irqEn, 2)));
endmodule

bind supply_warn_ctrl supply_warn_chk #(
  .SHORT_DELAY(SHORT_DELAY),
  .LONG_DELAY (LONG_DELAY)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .irqEn    (irqEn),
  .lvdEn    (lvdEn),
  .irqClr   (irqClr),
  .warnFlag (warnFlag),
  .irqPend  (irqPend)
);

// File: tb/supply_warn_ctrl_test.sv
module supply_warn_ctrl_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyCmp = 1'b0, pinCmp = 1'b0, srcSel = 1'b0, irqEn = 1'b0;
  logic lvdEn = 1'b1, longDelay = 1'b0, irqClr = 1'b0;
  logic warnFlag, irqPend;
  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  supply_warn_ctrl uut (
    .clk(clk), .rstN(rstN), .supplyCmp(supplyCmp), .pinCmp(pinCmp),
    .srcSel(srcSel), .irqEn(irqEn), .lvdEn(lvdEn), .longDelay(longDelay),
    .irqClr(irqClr), .warnFlag(warnFlag), .irqPend(irqPend)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b time=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clearPend();
    irqClr = 1'b1; step(1); irqClr = 1'b0;
  endtask

  task automatic doReset(logic longSel);
    longDelay = longSel;
    rstN = 1'b0;
    step(3);
    rstN = 1'b1;
  endtask

  task automatic testResetState();
    check("R3 reset flag", warnFlag, 1'b0);
    check("R5 reset pend", irqPend, 1'b0);
  endtask

  task automatic testShortWindow();
    step(10);
    supplyCmp = 1'b1; step(2);
    check("R6 flag tracks in window", warnFlag, 1'b1);
    step(3);
    check("R6 no irq in window fall", irqPend, 1'b0);
    supplyCmp = 1'b0; step(5);
    check("R6 no irq in window rise", irqPend, 1'b0);
    check("R6 flag back low", warnFlag, 1'b0);
  endtask

  task automatic testBothEdges();
    supplyCmp = 1'b1; step(1);
    check("R3 flag not before 2nd edge", warnFlag, 1'b0);
    step(1);
    check("R3 flag after 2nd edge", warnFlag, 1'b1);
    check("R4 pend not yet", irqPend, 1'b0);
    step(1);
    check("R4 pend on warning", irqPend, 1'b1);
    step(3);
    check("R5 pend sticky", irqPend, 1'b1);
    clearPend();
    check("R5 clear", irqPend, 1'b0);
    supplyCmp = 1'b0; step(3);
    check("R4 pend on recovery", irqPend, 1'b1);
  endtask

  task automatic testSetBeatsClear();
    // pend still set from previous scenario
    supplyCmp = 1'b1; step(2);
    irqClr = 1'b1; step(1); irqClr = 1'b0;
    check("R5 set beats clear", irqPend, 1'b1);
    clearPend();
    check("R5 clear after", irqPend, 1'b0);
    supplyCmp = 1'b0; step(3);
    clearPend();
    check("R5 clear recovery irq", irqPend, 1'b0);
  endtask

  task automatic testSourceSelect();
    pinCmp = 1'b1; step(4);
    check("R2 pin ignored when sel=0", warnFlag, 1'b0);
    srcSel = 1'b1; #1;
    check("R2 flag from pin", warnFlag, 1'b1);
    step(4);
    check("R9 select change no irq", irqPend, 1'b0);
    pinCmp = 1'b0; step(3);
    check("R2 pin crossing irq", irqPend, 1'b1);
    clearPend();
    supplyCmp = 1'b1; step(4);
    check("R2 supply ignored when sel=1", irqPend, 1'b0);
    srcSel = 1'b0; step(4);
    check("R9 select back no irq", irqPend, 1'b0);
    check("R2 flag from supply", warnFlag, 1'b1);
    supplyCmp = 1'b0; step(3);
    clearPend();
  endtask

  task automatic testDisabled();
    irqEn = 1'b0; step(1);
    supplyCmp = 1'b1; step(4);
    check("R10 flag moves", warnFlag, 1'b1);
    check("R10 no irq when disabled", irqPend, 1'b0);
    irqEn = 1'b1; step(1);
    check("R7 enable with warning", irqPend, 1'b1);
    clearPend();
    supplyCmp = 1'b0; step(3);
    check("R7 second irq on recovery", irqPend, 1'b1);
    clearPend();
    irqEn = 1'b0; step(2);
    irqEn = 1'b1; step(3);
    check("R8 enable without warning", irqPend, 1'b0);
  endtask

  task automatic testLvdOff();
    lvdEn = 1'b0;
    supplyCmp = 1'b1; step(5);
    check("R1 flag forced low", warnFlag, 1'b0);
    check("R1 no irq", irqPend, 1'b0);
    supplyCmp = 1'b0; step(5);
    check("R1 no irq on recovery", irqPend, 1'b0);
    lvdEn = 1'b1; step(2);
  endtask

  task automatic testLongWindow();
    irqEn = 1'b1;
    doReset(1'b1);
    step(1000);
    supplyCmp = 1'b1; step(5);
    check("R6 long window masks", irqPend, 1'b0);
    check("R6 long window flag", warnFlag, 1'b1);
    supplyCmp = 1'b0; step(5);
    step(3200);
    supplyCmp = 1'b1; step(3);
    check("R6 after long window irq", irqPend, 1'b1);
    supplyCmp = 1'b0; step(3);
    clearPend();
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    irqEn = 1'b1;
    doReset(1'b0);
    testResetState();
    testShortWindow();
    step(300);
    testBothEdges();
    testSetBeatsClear();
    testSourceSelect();
    testDisabled();
    testLvdOff();
    testLongWindow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule